// File: doc/BRIEF.md
# Access-Type-Aware Replacement Selector for One Cache Set

This block holds the replacement state of one set of a last-level cache. It uses static re-reference interval prediction, with one small counter per way, and it makes the insertion decision for every lookup that reaches the set. Each request carries four items:

- an access kind (load, store, writeback or prefetch);
- the hit result from the tag compare, with the hitting way;
- a keep-or-skip prediction from an external per-instruction classifier;
- a valid bit that marks the request.

Loads and stores are treated as demand traffic. A demand miss that the classifier marks as skip is not allocated, so the set is left as it was. A demand miss that the classifier marks as keep allocates through a victim search on the re-reference values. Writebacks and prefetches are not on the critical path of the core. A miss of either kind always allocates, always into way 0, and way 0 is then marked as the first way to evict. The tag store and the data array sit outside this block. They use the response, which is registered and appears one cycle after the request.

Top module: `lime_repl_sel`

## Requirements
- R1: A demand miss (request type 2'b00 load or 2'b01 store) with `pred_keep` low gives `rsp_bypass`=1 and `rsp_fill`=0, and it leaves every way's re-reference value unchanged.
- R2: A writeback miss (request type 2'b10) gives `rsp_fill`=1, `rsp_bypass`=0 and `rsp_way`=0, whatever `pred_keep` is.
- R3: A prefetch miss (request type 2'b11) gives `rsp_fill`=1, `rsp_bypass`=0 and `rsp_way`=0, whatever `pred_keep` is.
- R4: A demand miss with `pred_keep` high gives `rsp_fill`=1. Its `rsp_way` is the lowest-index way whose 2-bit value equals the maximum, 3.
- R5: When no way holds 3 at a demand fill, every way is aged in that same cycle by the gap between 3 and the current largest value. The victim is then chosen as in R4.
- R6: The victim of a demand fill is given the value 2.
- R7: A demand hit sets the hit way's value to 0. The response is `rsp_fill`=0, `rsp_bypass`=0 and `rsp_way` equal to `req_hit_way`.
- R8: A writeback or prefetch fill sets way 0 to 3. The next demand fill therefore picks way 0, and no other way is aged.
- R9: A writeback or prefetch hit gives the response of R7 but leaves every value unchanged.
- R10: The response appears with `rsp_valid`=1 exactly one clock after a request with `req_valid`=1. A cycle with no request gives `rsp_valid`=0 and `rsp_fill`=0 on the following clock.
- R11: After reset every way holds 3 and all response outputs are 0, so the first demand fill picks way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lookup result is presented this cycle |
| req_type | input | 2 | 00 load, 01 store, 10 writeback, 11 prefetch |
| req_hit | input | 1 | The lookup hit in this set |
| req_hit_way | input | WAY_W | Way that hit (used only when req_hit=1) |
| pred_keep | input | 1 | Classifier says a demand miss should be cached |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_bypass | output | 1 | Demand miss is not allocated |
| rsp_fill | output | 1 | Miss is allocated into rsp_way |
| rsp_way | output | WAY_W | Victim way for a fill, or the hit way for a hit |

## Verification
A demand fill does two things in one clock: it ages every way and it inserts into the victim, and the victim is chosen from the aged values. The bench provokes this by running more demand fills than there are ways after reset, and by running long pseudo-random streams in which hits keep pulling ways down below 3. Back-to-back requests also make each victim search read state written on the edge just before it. All of these cases are judged against an arithmetic model of the per-way values, which is updated in request order and checked on every response.

// File: rtl/lime_repl_pkg.sv
package lime_repl_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_WBACK = 2'b10,
      ACC_PREF  = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      UPD_NONE    = 2'b00,
      UPD_PROMOTE = 2'b01,
      UPD_DEMAND  = 2'b10,
      UPD_FIXED   = 2'b11
   } upd_kind_e;

   function automatic logic is_demand(input logic [1:0] kind);
      return ~kind[1];
   endfunction

endpackage

// File: rtl/lime_victim_find.sv
module lime_victim_find #(
   parameter int WAYS   = 4,
   parameter int RRPV_W = 2,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS*RRPV_W-1:0] rrpv_flat,
   output logic [WAY_W-1:0]       victim,
   output logic [RRPV_W-1:0]      age_amt
);
   localparam logic [RRPV_W-1:0] RMAX = {RRPV_W{1'b1}};

   logic [RRPV_W-1:0] top_val;

   always_comb begin
      top_val = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (rrpv_flat[i*RRPV_W +: RRPV_W] > top_val)
            top_val = rrpv_flat[i*RRPV_W +: RRPV_W];
      end
   end

   always_comb begin
      victim = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (rrpv_flat[i*RRPV_W +: RRPV_W] == top_val)
            victim = WAY_W'(i);
      end
   end

   assign age_amt = RMAX - top_val;

endmodule

// File: rtl/lime_rrpv_state.sv
module lime_rrpv_state
   import lime_repl_pkg::*;
#(
   parameter int WAYS        = 4,
   parameter int RRPV_W      = 2,
   parameter int INSERT_RRPV = 2,
   parameter int FIXED_WAY   = 0,
   localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  upd_kind_e              upd_kind,
   input  logic [WAY_W-1:0]       upd_way,
   input  logic [RRPV_W-1:0]      age_amt,
   output logic [WAYS*RRPV_W-1:0] rrpv_flat
);
   localparam logic [RRPV_W-1:0] RMAX = {RRPV_W{1'b1}};
   localparam logic [RRPV_W-1:0] RINS = RRPV_W'(INSERT_RRPV);

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic [RRPV_W-1:0] val_q;
      logic              sel;

      assign sel = (upd_way == WAY_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q <= RMAX;
         end else begin
            unique case (upd_kind)
               UPD_PROMOTE: if (sel) val_q <= '0;
               UPD_DEMAND:  val_q <= sel ? RINS : (val_q + age_amt);
               UPD_FIXED:   if (g == FIXED_WAY) val_q <= RMAX;
               default:     ;
            endcase
         end
      end

      assign rrpv_flat[g*RRPV_W +: RRPV_W] = val_q;
   end

endmodule

// File: rtl/lime_repl_sel.sv
module lime_repl_sel
   import lime_repl_pkg::*;
#(
   parameter int WAYS        = 4,
   parameter int RRPV_W      = 2,
   parameter int INSERT_RRPV = 2,
   parameter int FIXED_WAY   = 0,
   localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_type,
   input  logic             req_hit,
   input  logic [WAY_W-1:0] req_hit_way,
   input  logic             pred_keep,
   output logic             rsp_valid,
   output logic             rsp_bypass,
   output logic             rsp_fill,
   output logic [WAY_W-1:0] rsp_way
);
   if (WAYS < 2) begin : g_bad_ways
      $error("lime_repl_sel: WAYS must be at least 2");
   end
   if (RRPV_W < 1) begin : g_bad_width
      $error("lime_repl_sel: RRPV_W must be at least 1");
   end
   if (INSERT_RRPV < 0 || INSERT_RRPV >= (1 << RRPV_W)) begin : g_bad_ins
      $error("lime_repl_sel: INSERT_RRPV out of range");
   end
   if (FIXED_WAY < 0 || FIXED_WAY >= WAYS) begin : g_bad_fixed
      $error("lime_repl_sel: FIXED_WAY out of range");
   end

   logic [WAYS*RRPV_W-1:0] rrpv_flat;
   logic [WAY_W-1:0]       victim;
   logic [RRPV_W-1:0]      age_amt;
   upd_kind_e              upd_kind;
   logic [WAY_W-1:0]       upd_way;
   logic                   demand;

   assign demand = is_demand(req_type);

   lime_victim_find #(
      .WAYS   (WAYS),
      .RRPV_W (RRPV_W)
   ) u_find (
      .rrpv_flat (rrpv_flat),
      .victim    (victim),
      .age_amt   (age_amt)
   );

   always_comb begin
      upd_kind = UPD_NONE;
      upd_way  = victim;
      if (req_valid) begin
         if (req_hit) begin
            upd_way = req_hit_way;
            if (demand) upd_kind = UPD_PROMOTE;
         end else if (!demand) begin
            upd_kind = UPD_FIXED;
            upd_way  = WAY_W'(FIXED_WAY);
         end else if (pred_keep) begin
            upd_kind = UPD_DEMAND;
         end
      end
   end

   lime_rrpv_state #(
      .WAYS        (WAYS),
      .RRPV_W      (RRPV_W),
      .INSERT_RRPV (INSERT_RRPV),
      .FIXED_WAY   (FIXED_WAY)
   ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_kind  (upd_kind),
      .upd_way   (upd_way),
      .age_amt   (age_amt),
      .rrpv_flat (rrpv_flat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_bypass <= 1'b0;
         rsp_fill   <= 1'b0;
         rsp_way    <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_bypass <= req_valid && !req_hit && demand && !pred_keep;
         rsp_fill   <= req_valid && !req_hit && (!demand || pred_keep);
         rsp_way    <= req_valid ? upd_way : '0;
      end
   end

endmodule

// File: rtl/lime_repl_chk.sv
module lime_repl_chk #(
   parameter int WAYS  = 4,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       req_type,
   input logic             req_hit,
   input logic [WAY_W-1:0] req_hit_way,
   input logic             pred_keep,
   input logic             rsp_valid,
   input logic             rsp_bypass,
   input logic             rsp_fill,
   input logic [WAY_W-1:0] rsp_way
);
   // R10: response follows the request by one clock
   p_resp_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_resp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_fill));

   p_skip_demand_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hit && !req_type[1] && !pred_keep) |=> (rsp_bypass && !rsp_fill));

   p_wback_way0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hit && req_type == 2'b10) |=> (rsp_fill && !rsp_bypass && rsp_way == '0));

   p_pref_way0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hit && req_type == 2'b11) |=> (rsp_fill && !rsp_bypass && rsp_way == '0));

   p_keep_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hit && !req_type[1] && pred_keep) |=> (rsp_fill && !rsp_bypass));

   p_hit_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hit) |=> (!rsp_fill && !rsp_bypass && rsp_way == $past(req_hit_way)));

   p_fixed_then_demand_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hit && req_type[1]) ##1 (req_valid && !req_hit && !req_type[1] && pred_keep)
      |=> (rsp_way == '0));

endmodule

bind lime_repl_sel lime_repl_chk #(.WAYS(WAYS)) u_chk (.*);

// File: tb/lime_repl_sel_tb.sv
`timescale 1ns/1ps
module lime_repl_sel_tb;
   localparam int WAYS  = 4;
   localparam int WAY_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [1:0]       req_type = 2'b00;
   logic             req_hit = 1'b0;
   logic [WAY_W-1:0] req_hit_way = '0;
   logic             pred_keep = 1'b0;
   logic             rsp_valid, rsp_bypass, rsp_fill;
   logic [WAY_W-1:0] rsp_way;

   int checks = 0;
   int errors = 0;
   int mdl [WAYS];

   always #2 clk = ~clk;

   lime_repl_sel #(.WAYS(WAYS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
      .req_hit(req_hit), .req_hit_way(req_hit_way), .pred_keep(pred_keep),
      .rsp_valid(rsp_valid), .rsp_bypass(rsp_bypass), .rsp_fill(rsp_fill),
      .rsp_way(rsp_way)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic issue(input logic [1:0] t, input logic h, input int hw, input logic k);
      int    ew, mx;
      logic  ef, eb;
      string tag;
      ef = 1'b0; eb = 1'b0; ew = 0;
      if (h) begin
         ew  = hw;
         tag = t[1] ? "R9 hit" : "R7 hit";
         if (!t[1]) mdl[hw] = 0;
      end else if (t[1]) begin
         ef = 1'b1; ew = 0; mdl[0] = 3;
         tag = (t == 2'b10) ? "R2 wback" : "R3 pref";
      end else if (!k) begin
         eb = 1'b1; tag = "R1 skip";
      end else begin
         mx = 0;
         for (int i = 0; i < WAYS; i++) if (mdl[i] > mx) mx = mdl[i];
         tag = (mx < 3) ? "R5 aged fill" : "R4 fill";
         for (int i = 0; i < WAYS; i++) mdl[i] += 3 - mx;
         ew = -1;
         for (int i = WAYS - 1; i >= 0; i--) if (mdl[i] == 3) ew = i;
         mdl[ew] = 2;  // R6 insertion value
         ef = 1'b1;
      end
      req_valid = 1'b1; req_type = t; req_hit = h;
      req_hit_way = WAY_W'(hw); pred_keep = k;
      @(negedge clk);
      chk({tag, " valid R10"}, int'(rsp_valid), 1);
      chk({tag, " fill"}, int'(rsp_fill), int'(ef));
      chk({tag, " bypass"}, int'(rsp_bypass), int'(eb));
      if (ef || h) chk({tag, " way"}, int'(rsp_way), ew);
   endtask

   task automatic idle();
      req_valid = 1'b0;
      @(negedge clk);
      chk("R10 idle valid", int'(rsp_valid), 0);
      chk("R10 idle fill", int'(rsp_fill), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [15:0] lfsr;
      for (int i = 0; i < WAYS; i++) mdl[i] = 3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R11 reset valid", int'(rsp_valid), 0);
      chk("R11 reset fill", int'(rsp_fill), 0);
      chk("R11 reset bypass", int'(rsp_bypass), 0);
      chk("R11 reset way", int'(rsp_way), 0);

      // directed: fill every way, then force aging (R5), hits, skips, fixed fills
      for (int i = 0; i < WAYS; i++) issue(2'(i % 2), 1'b0, 0, 1'b1);
      issue(2'b00, 1'b0, 0, 1'b1);           // R5
      issue(2'b00, 1'b1, 1, 1'b0);           // R7
      issue(2'b01, 1'b0, 0, 1'b0);           // R1
      issue(2'b00, 1'b0, 0, 1'b1);
      idle();
      issue(2'b10, 1'b0, 0, 1'b0);           // R2
      issue(2'b00, 1'b0, 0, 1'b1);           // R8 -> way 0
      issue(2'b11, 1'b0, 0, 1'b1);           // R3
      issue(2'b11, 1'b1, 2, 1'b0);           // R9
      issue(2'b10, 1'b1, 3, 1'b1);           // R9
      issue(2'b00, 1'b0, 0, 1'b1);           // R8 -> way 0
      issue(2'b00, 1'b0, 0, 1'b1);

      // near-exhaustive pseudo-random sweep of type/hit/way/keep
      lfsr = 16'hACE1;
      for (int n = 0; n < 4000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[7:5] == 3'b000) idle();
         else issue(lfsr[1:0], lfsr[2] & lfsr[8], int'(lfsr[4:3]), lfsr[9] | lfsr[11]);
      end
      idle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule